// File: doc/BRIEF.md
# PCIe Configuration Access Address Generator

This block sits between a host-side configuration request port and the register window of a PCIe root port. Each request names a bus, device, function, register offset, access size, direction and write data. The block decides whether the target can exist and whether the request is well formed. It then routes the access either to the root port's own configuration registers or, through a setup word, to a remote configuration window.

The root port is modelled as a bridge with a virtual secondary bus. Bus 0 holds only the root port itself, which is reached through the local region. Bus 1 holds the single downstream device, which is reached by Type 0 accesses. Any bus number above 1 lies behind a further bridge and is reached by Type 1 accesses. Nothing is forwarded unless the link training state reports L0. Requests that are refused finish at once and report all ones as read data, the value software uses to detect absent functions.

Reads always fetch the aligned word. The block then moves the addressed byte or halfword down to bit 0. Writes travel with a byte-enable vector, and only the enabled lanes carry data. One request is handled at a time, and every accepted request ends with a one-cycle completion pulse and a status flag.

Top module: `cfg_route_gen`

## Requirements
- R1: A request to bus 0 drives `acc_addr` = 0x1000 + (offset with its two low bits cleared) and never raises `setup_we`.
- R2: A request to a bus other than 0 raises `setup_we` for one cycle, and `acc_valid` follows in the next cycle at address 0x2000 + the aligned offset. The setup word carries the bus in bits 23:16, the device in bits 15:8 and the function in bits 7:0, and all other bits are 0 apart from bit 24.
- R3: Setup word bit 24 (the Type 1 select) is 1 exactly when the bus number is greater than 1, so bus 1 gets Type 0.
- R4: When bits 4:0 of `link_stat` differ from 0x11, the request is refused. The bits above 4 are ignored. A refused request gives no setup write and no access, and it completes with `done_ok`=0 and `done_rdata` of all ones.
- R5: On buses 0 and 1 only device 0 is present, and any other device number is refused as in R4. On buses 2 and above every device number is forwarded.
- R6: The size code is 0 for a byte, 1 for a halfword and 2 for a word. A successful read returns the fetched word shifted right by 8 times offset bits 1:0. A byte read keeps the low 8 bits of the result and a halfword read keeps the low 16 bits, with the rest zero.
- R7: A write drives `acc_be` bit i for each byte lane i from offset bits 1:0 up to that value plus the size in bytes minus 1. Write data is shifted left by 8 times offset bits 1:0, and lanes that are not enabled are driven as zero.
- R8: A halfword at an odd offset, a word whose offset bits 1:0 are not 00, and size code 3 are all refused as in R4.
- R9: `req_ready` is low from the cycle after a request is accepted until its `done` pulse ends. `done` lasts one cycle. Requests presented while busy are ignored.
- R10: While `acc_valid` is high and `acc_ack` is low, the access address, enables and data stay stable. After reset, `req_ready` is 1 and `done`, `acc_valid` and `setup_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_bus | input | BUS_W | Target bus number |
| req_dev | input | DEV_W | Target device number |
| req_fn | input | FN_W | Target function number |
| req_off | input | OFF_W | Configuration register byte offset |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | DATA_W | Write data, right-aligned |
| link_stat | input | LINK_W | Link debug status; bits 4:0 hold the training state |
| setup_we | output | 1 | Write strobe for the remote setup register |
| setup_word | output | 32 | Value for the remote setup register |
| acc_valid | output | 1 | Word access to the configuration window |
| acc_addr | output | ADDR_W | Word-aligned module-space address |
| acc_write | output | 1 | Access direction |
| acc_be | output | LANES | Byte enables of the access |
| acc_wdata | output | DATA_W | Lane-placed write data |
| acc_ack | input | 1 | Access completed this cycle |
| acc_rdata | input | DATA_W | Read word, valid with acc_ack |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | 1 for success, 0 for not found |
| done_rdata | output | DATA_W | Extracted read data; all ones when refused, zero for a write |

## Verification
The assertions cover the cycle-level rules on every cycle: the completion pulse length, the busy window after acceptance, the setup write followed by an access, the stable access while no acknowledge arrives, a legal count of byte enables, no setup word for bus 0, and all ones on a refused completion. Only the bench scenarios can show that decode values are right. These are the exact address, the setup word fields and Type bit for a given bus, the presence verdict for each bus and device pair, the lane-shifted read and write data, and that a request arriving while the block is busy is dropped.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } cfg_size_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_ACCESS = 2'd2,
      ST_DONE   = 2'd3
   } cfg_state_e;

   // Training-state code meaning the link is up
   localparam logic [4:0] LINK_UP_CODE = 5'h11;

   // Setup word field positions (decoded by the remote window logic)
   localparam int SETUP_W     = 32;
   localparam int SETUP_TYPE1 = 24;
   localparam int SETUP_BUS   = 16;
   localparam int SETUP_DEV   = 8;
   localparam int SETUP_FN    = 0;

endpackage

// File: rtl/cfg_route_decode.sv
module cfg_route_decode
   import cfg_route_pkg::*;
#(
   parameter int BUS_W   = 8,
   parameter int DEV_W   = 5,
   parameter int FN_W    = 3,
   parameter int OFF_W   = 12,
   parameter int LINK_W  = 8,
   parameter int ADDR_W  = 14,
   parameter int LANE_AW = 2,
   parameter logic [ADDR_W-1:0] LOCAL_BASE  = ADDR_W'(14'h1000),
   parameter logic [ADDR_W-1:0] REMOTE_BASE = ADDR_W'(14'h2000)
) (
   input  logic [BUS_W-1:0]   bus,
   input  logic [DEV_W-1:0]   dev,
   input  logic [FN_W-1:0]    fn,
   input  logic [OFF_W-1:0]   off,
   input  logic [1:0]         size,
   input  logic [LINK_W-1:0]  link,
   output logic               accept,
   output logic               remote,
   output logic [SETUP_W-1:0] setup,
   output logic [ADDR_W-1:0]  word_addr
);

   localparam logic [1:0] MAX_SZ = 2'(LANE_AW);

   logic                link_up;
   logic                dev_exists;
   logic                size_ok;
   logic [LANE_AW-1:0]  low_mask;
   logic                aligned;
   logic                beyond_virt;

   assign link_up     = (link[4:0] == LINK_UP_CODE);
   assign beyond_virt = (bus > BUS_W'(1));
   // Buses 0 and 1 hold a single device; deeper buses are not filtered
   assign dev_exists  = beyond_virt || (dev == '0);

   assign size_ok  = (size <= MAX_SZ);
   assign low_mask = LANE_AW'((1 << size) - 1);
   assign aligned  = size_ok && ((off[LANE_AW-1:0] & low_mask) == '0);

   assign accept = link_up && dev_exists && aligned;
   assign remote = (bus != '0);

   always_comb begin
      setup = '0;
      setup[SETUP_BUS +: BUS_W] = bus;
      setup[SETUP_DEV +: DEV_W] = dev;
      setup[SETUP_FN  +: FN_W]  = fn;
      setup[SETUP_TYPE1]        = beyond_virt;
   end

   assign word_addr = (remote ? REMOTE_BASE : LOCAL_BASE)
                    + ADDR_W'({off[OFF_W-1:LANE_AW], {LANE_AW{1'b0}}});

endmodule

// File: rtl/cfg_route_lanes.sv
module cfg_route_lanes #(
   parameter int DATA_W = 32,
   localparam int LANES   = DATA_W / 8,
   localparam int LANE_AW = $clog2(LANES)
) (
   input  logic [LANE_AW-1:0] off_lo,
   input  logic [1:0]         size,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [DATA_W-1:0]  rdata_raw,
   output logic [LANES-1:0]   be,
   output logic [DATA_W-1:0]  wdata_lanes,
   output logic [DATA_W-1:0]  rdata_ext
);

   int                span;
   logic [DATA_W-1:0] w_shift;
   logic [DATA_W-1:0] r_shift;

   assign span    = 1 << size;
   assign w_shift = wdata << {off_lo, 3'b000};
   assign r_shift = rdata_raw >> {off_lo, 3'b000};

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign be[i] = (i >= int'(off_lo)) && (i < int'(off_lo) + span);
      assign wdata_lanes[8*i +: 8] = be[i] ? w_shift[8*i +: 8] : 8'h00;
      assign rdata_ext[8*i +: 8]   = (i < span) ? r_shift[8*i +: 8] : 8'h00;
   end

endmodule

// File: rtl/cfg_route_gen.sv
module cfg_route_gen
   import cfg_route_pkg::*;
#(
   parameter int BUS_W   = 8,
   parameter int DEV_W   = 5,
   parameter int FN_W    = 3,
   parameter int OFF_W   = 12,
   parameter int LINK_W  = 8,
   parameter int ADDR_W  = 14,
   parameter int DATA_W  = 32,
   parameter logic [ADDR_W-1:0] LOCAL_BASE  = ADDR_W'(14'h1000),
   parameter logic [ADDR_W-1:0] REMOTE_BASE = ADDR_W'(14'h2000),
   localparam int LANES   = DATA_W / 8,
   localparam int LANE_AW = $clog2(LANES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [BUS_W-1:0]   req_bus,
   input  logic [DEV_W-1:0]   req_dev,
   input  logic [FN_W-1:0]    req_fn,
   input  logic [OFF_W-1:0]   req_off,
   input  logic [1:0]         req_size,
   input  logic               req_write,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic [LINK_W-1:0]  link_stat,
   output logic               setup_we,
   output logic [31:0]        setup_word,
   output logic               acc_valid,
   output logic [ADDR_W-1:0]  acc_addr,
   output logic               acc_write,
   output logic [LANES-1:0]   acc_be,
   output logic [DATA_W-1:0]  acc_wdata,
   input  logic               acc_ack,
   input  logic [DATA_W-1:0]  acc_rdata,
   output logic               done,
   output logic               done_ok,
   output logic [DATA_W-1:0]  done_rdata
);

   initial begin : g_param_check
      assert (DATA_W == 32 || DATA_W == 64)
         else $error("DATA_W must be 32 or 64");
      assert (BUS_W <= 8 && DEV_W <= 8 && FN_W <= 8)
         else $error("bus, device and function fields are limited to 8 bits");
      assert (OFF_W > LANE_AW) else $error("OFF_W too small");
      assert (LINK_W >= 5) else $error("LINK_W must hold the 5-bit state");
      assert (ADDR_W > OFF_W) else $error("ADDR_W must exceed OFF_W");
   end

   cfg_state_e           state_q;
   logic                 remote_q;
   logic [SETUP_W-1:0]   setup_q;
   logic [ADDR_W-1:0]    addr_q;
   logic [LANE_AW-1:0]   off_lo_q;
   logic [1:0]           size_q;
   logic                 write_q;
   logic [DATA_W-1:0]    wdata_q;
   logic                 ok_q;
   logic [DATA_W-1:0]    rdata_q;

   logic                 dec_accept;
   logic                 dec_remote;
   logic [SETUP_W-1:0]   dec_setup;
   logic [ADDR_W-1:0]    dec_addr;
   logic [DATA_W-1:0]    rd_ext;
   logic                 take;

   cfg_route_decode #(
      .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W),
      .LINK_W(LINK_W), .ADDR_W(ADDR_W), .LANE_AW(LANE_AW),
      .LOCAL_BASE(LOCAL_BASE), .REMOTE_BASE(REMOTE_BASE)
   ) i_decode (
      .bus(req_bus), .dev(req_dev), .fn(req_fn), .off(req_off),
      .size(req_size), .link(link_stat),
      .accept(dec_accept), .remote(dec_remote),
      .setup(dec_setup), .word_addr(dec_addr)
   );

   cfg_route_lanes #(.DATA_W(DATA_W)) i_lanes (
      .off_lo(off_lo_q), .size(size_q), .wdata(wdata_q),
      .rdata_raw(acc_rdata), .be(acc_be),
      .wdata_lanes(acc_wdata), .rdata_ext(rd_ext)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign take      = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         remote_q <= 1'b0;
         setup_q  <= '0;
         addr_q   <= '0;
         off_lo_q <= '0;
         size_q   <= '0;
         write_q  <= 1'b0;
         wdata_q  <= '0;
         ok_q     <= 1'b0;
         rdata_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (take) begin
               remote_q <= dec_remote;
               setup_q  <= dec_setup;
               addr_q   <= dec_addr;
               off_lo_q <= req_off[LANE_AW-1:0];
               size_q   <= req_size;
               write_q  <= req_write;
               wdata_q  <= req_wdata;
               ok_q     <= dec_accept;
               rdata_q  <= '1;
               if (!dec_accept)     state_q <= ST_DONE;
               else if (dec_remote) state_q <= ST_SETUP;
               else                 state_q <= ST_ACCESS;
            end
            ST_SETUP:  state_q <= ST_ACCESS;
            ST_ACCESS: if (acc_ack) begin
               rdata_q <= write_q ? '0 : rd_ext;
               state_q <= ST_DONE;
            end
            ST_DONE:   state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   assign setup_we   = (state_q == ST_SETUP);
   assign setup_word = setup_q;
   assign acc_valid  = (state_q == ST_ACCESS);
   assign acc_addr   = addr_q;
   assign acc_write  = write_q;
   assign done       = (state_q == ST_DONE);
   assign done_ok    = done && ok_q;
   assign done_rdata = rdata_q;

   // R9: completion is a single-cycle pulse
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: no new request is taken directly after acceptance
   p_busy_after_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !req_ready);

   // R2: the setup write is followed at once by the access
   p_setup_then_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
      setup_we |=> acc_valid);

   // R1: the local bus never programs the remote setup register
   p_no_setup_bus0_r1: assert property (@(posedge clk) disable iff (!rst_n)
      setup_we |-> (setup_word[SETUP_BUS +: 8] != 8'h00));

   // R10: a waiting access holds its address, enables and data
   p_hold_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_ack) |=> (acc_valid && $stable(acc_addr)
                                   && $stable(acc_be) && $stable(acc_wdata)));

   // R7: enabled lanes form a byte, halfword or word
   p_be_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> ($countones(acc_be) == 1 || $countones(acc_be) == 2
                     || $countones(acc_be) == 4));

   // R4: a refused request reports all ones
   p_refused_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_ok) |-> (done_rdata == '1));

endmodule

// File: tb/test_cfg_route_gen.sv
`timescale 1ns/1ps
module test_cfg_route_gen;

   localparam logic [31:0] RD_WORD = 32'hA1B2C3D4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [7:0]  req_bus = '0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_fn = '0;
   logic [11:0] req_off = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic [7:0]  link_stat = 8'h11;
   logic        setup_we;
   logic [31:0] setup_word;
   logic        acc_valid;
   logic [13:0] acc_addr;
   logic        acc_write;
   logic [3:0]  acc_be;
   logic [31:0] acc_wdata;
   logic        acc_ack = 1'b0;
   logic [31:0] acc_rdata = '0;
   logic        done;
   logic        done_ok;
   logic [31:0] done_rdata;

   int n_checks = 0;
   int n_errors = 0;

   always #4 clk = ~clk;

   cfg_route_gen i_cfg_route_gen (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn),
      .req_off(req_off), .req_size(req_size), .req_write(req_write),
      .req_wdata(req_wdata), .link_stat(link_stat),
      .setup_we(setup_we), .setup_word(setup_word),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
      .acc_be(acc_be), .acc_wdata(acc_wdata),
      .acc_ack(acc_ack), .acc_rdata(acc_rdata),
      .done(done), .done_ok(done_ok), .done_rdata(done_rdata)
   );

   task automatic check(input bit cond, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!cond) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Observed results of one request
   bit          s_setup, s_acc, s_done, s_pulse_ok;
   logic [31:0] s_setup_word, s_wdata, s_rdata;
   logic [13:0] s_addr;
   logic [3:0]  s_be;
   logic        s_ok, s_wr;
   int          s_setup_cyc, s_acc_cyc;

   task automatic run_req(input logic [7:0] bus, input logic [4:0] dev,
                          input logic [2:0] fn, input logic [11:0] off,
                          input logic [1:0] size, input logic wr,
                          input logic [31:0] wdata, input int ack_delay);
      int waited = 0;
      s_setup = 0; s_acc = 0; s_done = 0; s_pulse_ok = 0;
      s_setup_cyc = -1; s_acc_cyc = -1;
      @(negedge clk);
      req_bus = bus; req_dev = dev; req_fn = fn; req_off = off;
      req_size = size; req_write = wr; req_wdata = wdata; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int cyc = 0; cyc < 40; cyc++) begin
         acc_ack = 1'b0;
         if (setup_we) begin
            s_setup = 1; s_setup_word = setup_word; s_setup_cyc = cyc;
         end
         if (acc_valid) begin
            if (!s_acc) begin
               s_acc = 1; s_acc_cyc = cyc; s_addr = acc_addr;
               s_be = acc_be; s_wdata = acc_wdata; s_wr = acc_write;
            end
            if (waited >= ack_delay) begin
               acc_ack = 1'b1; acc_rdata = RD_WORD;
            end
            waited++;
         end
         if (done) begin
            s_done = 1; s_ok = done_ok; s_rdata = done_rdata;
            break;
         end
         @(negedge clk);
      end
      @(negedge clk);
      acc_ack = 1'b0;
      s_pulse_ok = !done && req_ready;
   endtask

   typedef struct packed {
      logic [7:0]  bus;
      logic [4:0]  dev;
      logic [2:0]  fn;
      logic [11:0] off;
      logic [1:0]  size;
      logic        wr;
      logic [31:0] wdata;
      logic        ok;
      logic        remote;
      logic [13:0] addr;
      logic [3:0]  be;
      logic [31:0] data;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{8'd0,   5'd0,  3'd0, 12'h010, 2'd2, 1'b0, 32'h0,        1'b1, 1'b0, 14'h1010, 4'hF, 32'hA1B2C3D4},
      '{8'd0,   5'd0,  3'd0, 12'h013, 2'd0, 1'b0, 32'h0,        1'b1, 1'b0, 14'h1010, 4'h8, 32'h000000A1},
      '{8'd0,   5'd0,  3'd0, 12'h006, 2'd1, 1'b0, 32'h0,        1'b1, 1'b0, 14'h1004, 4'hC, 32'h0000A1B2},
      '{8'd0,   5'd1,  3'd0, 12'h000, 2'd2, 1'b0, 32'h0,        1'b0, 1'b0, 14'h0,    4'h0, 32'hFFFFFFFF},
      '{8'd1,   5'd0,  3'd2, 12'h100, 2'd2, 1'b0, 32'h0,        1'b1, 1'b1, 14'h2100, 4'hF, 32'hA1B2C3D4},
      '{8'd1,   5'd3,  3'd0, 12'h000, 2'd2, 1'b0, 32'h0,        1'b0, 1'b0, 14'h0,    4'h0, 32'hFFFFFFFF},
      '{8'd5,   5'd3,  3'd1, 12'h041, 2'd0, 1'b0, 32'h0,        1'b1, 1'b1, 14'h2040, 4'h2, 32'h000000C3},
      '{8'd0,   5'd0,  3'd0, 12'h022, 2'd1, 1'b1, 32'h1234BEEF, 1'b1, 1'b0, 14'h1020, 4'hC, 32'hBEEF0000},
      '{8'd2,   5'd31, 3'd7, 12'hFFD, 2'd0, 1'b1, 32'hFFFFFF5A, 1'b1, 1'b1, 14'h2FFC, 4'h2, 32'h00005A00},
      '{8'd0,   5'd0,  3'd0, 12'h003, 2'd1, 1'b0, 32'h0,        1'b0, 1'b0, 14'h0,    4'h0, 32'hFFFFFFFF},
      '{8'd0,   5'd0,  3'd0, 12'h000, 2'd3, 1'b0, 32'h0,        1'b0, 1'b0, 14'h0,    4'h0, 32'hFFFFFFFF},
      '{8'd1,   5'd0,  3'd0, 12'h000, 2'd2, 1'b1, 32'h12345678, 1'b1, 1'b1, 14'h2000, 4'hF, 32'h12345678},
      '{8'd255, 5'd0,  3'd0, 12'h002, 2'd1, 1'b0, 32'h0,        1'b1, 1'b1, 14'h2000, 4'hC, 32'h0000A1B2}
   };

   function automatic logic [31:0] exp_setup(input logic [7:0] bus,
                                             input logic [4:0] dev,
                                             input logic [2:0] fn);
      return {7'b0, (bus > 8'd1), bus, 3'b0, dev, 5'b0, fn};
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : main
      int dones;
      // R10: reset state
      repeat (3) @(negedge clk);
      check(req_ready == 1'b1, "R10 ready in reset", 32'(req_ready), 32'h1);
      check(!done && !acc_valid && !setup_we, "R10 outputs idle in reset",
            {29'b0, done, acc_valid, setup_we}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table of vectors, link in L0
      for (int v = 0; v < NV; v++) begin
         vec_t t = VECS[v];
         run_req(t.bus, t.dev, t.fn, t.off, t.size, t.wr, t.wdata, v % 3);
         check(s_done, "R9 completion seen", 32'(s_done), 32'h1);
         check(s_pulse_ok, "R9 single done pulse then ready", 32'(s_pulse_ok), 32'h1);
         check(s_ok == t.ok, "R5 R8 presence/alignment status", 32'(s_ok), 32'(t.ok));
         if (t.ok) begin
            check(s_acc, "R1 R2 access issued", 32'(s_acc), 32'h1);
            check(s_addr == t.addr, "R1 R2 access address", 32'(s_addr), 32'(t.addr));
            check(s_wr == t.wr, "R7 access direction", 32'(s_wr), 32'(t.wr));
            if (t.remote) begin
               check(s_setup, "R2 setup write issued", 32'(s_setup), 32'h1);
               check(s_setup_word == exp_setup(t.bus, t.dev, t.fn),
                     "R2 R3 setup word", s_setup_word, exp_setup(t.bus, t.dev, t.fn));
               check(s_acc_cyc == s_setup_cyc + 1, "R2 setup one cycle before access",
                     32'(s_acc_cyc), 32'(s_setup_cyc + 1));
            end else begin
               check(!s_setup, "R1 no setup for bus 0", 32'(s_setup), 32'h0);
            end
            if (t.wr) begin
               check(s_be == t.be, "R7 byte enables", 32'(s_be), 32'(t.be));
               check(s_wdata == t.data, "R7 lane data", s_wdata, t.data);
            end else begin
               check(s_rdata == t.data, "R6 extracted read data", s_rdata, t.data);
            end
         end else begin
            check(!s_acc && !s_setup, "R4 R5 R8 nothing forwarded",
                  {30'b0, s_acc, s_setup}, 32'h0);
            check(s_rdata == 32'hFFFFFFFF, "R4 refused data all ones",
                  s_rdata, 32'hFFFFFFFF);
         end
      end

      // R4: link not in L0
      link_stat = 8'h10;
      run_req(8'd0, 5'd0, 3'd0, 12'h000, 2'd2, 1'b0, 32'h0, 0);
      check(s_done && !s_ok, "R4 link down refused", 32'(s_ok), 32'h0);
      check(!s_acc, "R4 link down no access", 32'(s_acc), 32'h0);
      check(s_rdata == 32'hFFFFFFFF, "R4 link down all ones", s_rdata, 32'hFFFFFFFF);
      run_req(8'd3, 5'd0, 3'd0, 12'h000, 2'd2, 1'b0, 32'h0, 0);
      check(!s_setup && !s_acc, "R4 link down no remote traffic",
            {30'b0, s_setup, s_acc}, 32'h0);
      // R4: bits above 4 ignored
      link_stat = 8'hF1;
      run_req(8'd0, 5'd0, 3'd0, 12'h004, 2'd2, 1'b0, 32'h0, 0);
      check(s_ok && s_rdata == RD_WORD, "R4 upper status bits ignored", s_rdata, RD_WORD);
      link_stat = 8'h11;

      // R10 and R9: held access, second request while busy is ignored
      @(negedge clk);
      req_bus = 8'd1; req_dev = 5'd0; req_fn = 3'd0; req_off = 12'h008;
      req_size = 2'd2; req_write = 1'b0; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_bus = 8'd0; req_off = 12'h00C;
      check(req_ready == 1'b0, "R9 busy after accept", 32'(req_ready), 32'h0);
      @(negedge clk);
      check(acc_valid && acc_addr == 14'h2008, "R10 access pending", 32'(acc_addr), 32'h2008);
      repeat (3) @(negedge clk);
      check(acc_valid && acc_addr == 14'h2008, "R10 access held without ack",
            32'(acc_addr), 32'h2008);
      check(req_ready == 1'b0, "R9 still busy", 32'(req_ready), 32'h0);
      req_valid = 1'b0;
      acc_ack = 1'b1; acc_rdata = RD_WORD;
      @(negedge clk);
      acc_ack = 1'b0;
      dones = 0;
      for (int c = 0; c < 8; c++) begin
         if (done) dones++;
         check(!(acc_valid && acc_addr == 14'h100C), "R9 busy request dropped",
               32'(acc_addr), 32'h2008);
         @(negedge clk);
      end
      check(dones == 1, "R9 one completion for two presentations", 32'(dones), 32'h1);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule